// File: doc/BRIEF.md
# Two-Bank Pin Controller with Atomic Set and Clear

This block controls 32 general-purpose pins arranged as two banks of 16. Each control function occupies one 32-bit register word. The lower bank sits in bits 15:0, and pin n of that bank is bit n. The upper bank sits in bits 31:16, and pin n of that bank is bit 16+n. For every pin the block keeps three things:

- a direction bit, where 0 selects output and 1 selects input;
- an output latch;
- a synchronized copy of the level present on the pad.

Software changes individual latches without a read-modify-write cycle. A write-one-to-set word raises the latches it names, and a write-one-to-clear word lowers them. The output word can also load all 32 latches at once. Reading the set, clear or output word returns the latches. The pad levels come back through a separate input word. The per-pin enable and data outputs drive external tristate pad buffers.

The register bus is a simple strobe interface with a 3-bit word address. A write takes effect at the clock edge where it is sampled. Read data is registered and comes back one clock after the read strobe, together with a valid pulse.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every direction bit is 1 and every output latch is 0, so `pad_oe` and `pad_out` are all zero.
- R2: A write to word address 0 loads the direction bits. Bit k of `pad_oe` is 1 exactly when direction bit k is 0. Bits 15:0 are lower-bank pins 0..15 and bits 31:16 are upper-bank pins 0..15.
- R3: A write to word address 2 sets to 1 every latch whose data bit is 1, and leaves latches with a 0 data bit unchanged.
- R4: A write to word address 3 clears to 0 every latch whose data bit is 1, and leaves latches with a 0 data bit unchanged.
- R5: A write to word address 1 loads all 32 output latches from the write data.
- R6: Reads of word addresses 1, 2 and 3 all return the output latches, whatever the direction bits hold. A read of address 0 returns the direction bits.
- R7: A read of word address 4 returns the pad levels after a two-flop synchronizer. A pad change made before clock edge E is visible to a read strobe sampled at edge E+2 but not to one sampled at E+1. Writes to address 4 change nothing.
- R8: `bus_rdata` and `bus_rvalid` are updated at the clock edge that samples `bus_rd`, so `bus_rvalid` is high for exactly the cycle after a read strobe. Reads of addresses 5 to 7 return 0, and writes to them change nothing.
- R9: `pad_out` always presents the output latches, including for pins whose direction bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| pad_in | input | 32 | Pad levels, asynchronous |
| pad_oe | output | 32 | Per-pin pad output enable |
| pad_out | output | 32 | Per-pin pad output data |

## Verification
The case that is hardest to reach from the ports is the exact depth of the input synchronizer. A read only shows the pad level once it has passed through both flops and the read register. To observe the boundary, the bench changes `pad_in` on a falling edge and then issues the read strobe after exactly one rising edge, then again after exactly two. The first read must return the old level and the second the new one. Single-bit set and clear are walked across all 32 pins, with each readback rotating among the output, set and clear words. Each step is compared against a bench-side latch model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_DIR = 3'd0,
    REG_OUT = 3'd1,
    REG_SET = 3'd2,
    REG_CLR = 3'd3,
    REG_IN  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_dir,
  input  logic             wr_out,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] lat_q
);
  // Next latch value: a direct load replaces the word, then set masks
  // raise bits, then clear masks lower them (clear wins on overlap).
  function automatic logic [WIDTH-1:0] next_latch(
    input logic [WIDTH-1:0] cur,
    input logic             load_en,
    input logic [WIDTH-1:0] load_val,
    input logic [WIDTH-1:0] set_m,
    input logic [WIDTH-1:0] clr_m
  );
    logic [WIDTH-1:0] base;
    base = load_en ? load_val : cur;
    return (base | set_m) & ~clr_m;
  endfunction

  logic [WIDTH-1:0] set_mask, clr_mask, lat_d;

  assign set_mask = wr_set ? wdata : '0;
  assign clr_mask = wr_clr ? wdata : '0;
  assign lat_d    = next_latch(lat_q, wr_out, wdata, set_mask, clr_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      lat_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      lat_q <= lat_d;
    end
  end
endmodule

// File: rtl/gpio_rd_port.sv
module gpio_rd_port
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [REG_AW-1:0] addr,
  input  logic [WIDTH-1:0]  dir_q,
  input  logic [WIDTH-1:0]  lat_q,
  input  logic [WIDTH-1:0]  pin_lvl,
  output logic [WIDTH-1:0]  rdata,
  output logic              rvalid
);
  logic [WIDTH-1:0] sel_word;

  always_comb begin
    unique case (addr)
      REG_DIR:                   sel_word = dir_q;
      REG_OUT, REG_SET, REG_CLR: sel_word = lat_q;
      REG_IN:                    sel_word = pin_lvl;
      default:                   sel_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      rdata  <= rd ? sel_word : '0;
    end
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned BANK_W    = 16,
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [REG_AW-1:0]             bus_addr,
  input  logic [BANK_W*NUM_BANKS-1:0]   bus_wdata,
  output logic [BANK_W*NUM_BANKS-1:0]   bus_rdata,
  output logic                          bus_rvalid,
  input  logic [BANK_W*NUM_BANKS-1:0]   pad_in,
  output logic [BANK_W*NUM_BANKS-1:0]   pad_oe,
  output logic [BANK_W*NUM_BANKS-1:0]   pad_out
);
  localparam int unsigned PIN_W = BANK_W * NUM_BANKS;

  // Named decode events, visible to the checker.
  logic wr_dir_hit, wr_out_hit, wr_set_hit, wr_clr_hit;
  assign wr_dir_hit = bus_wr && (bus_addr == REG_DIR);
  assign wr_out_hit = bus_wr && (bus_addr == REG_OUT);
  assign wr_set_hit = bus_wr && (bus_addr == REG_SET);
  assign wr_clr_hit = bus_wr && (bus_addr == REG_CLR);

  logic [PIN_W-1:0] dir_q, lat_q, pin_lvl;

  gpio_ctrl_regs #(.WIDTH(PIN_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_dir (wr_dir_hit),
    .wr_out (wr_out_hit),
    .wr_set (wr_set_hit),
    .wr_clr (wr_clr_hit),
    .wdata  (bus_wdata),
    .dir_q  (dir_q),
    .lat_q  (lat_q)
  );

  gpio_in_sync #(.WIDTH(PIN_W), .STAGES(SYNC_LEN)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pin_lvl)
  );

  gpio_rd_port #(.WIDTH(PIN_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd      (bus_rd),
    .addr    (bus_addr),
    .dir_q   (dir_q),
    .lat_q   (lat_q),
    .pin_lvl (pin_lvl),
    .rdata   (bus_rdata),
    .rvalid  (bus_rvalid)
  );

  // Per-bank pad drive: enable is the inverse of the direction bit.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign pad_oe [b*BANK_W +: BANK_W] = ~dir_q[b*BANK_W +: BANK_W];
    assign pad_out[b*BANK_W +: BANK_W] =  lat_q[b*BANK_W +: BANK_W];
  end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PIN_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [REG_AW-1:0] bus_addr,
  input logic [PIN_W-1:0]  bus_wdata,
  input logic [PIN_W-1:0]  bus_rdata,
  input logic              bus_rvalid,
  input logic [PIN_W-1:0]  pad_in,
  input logic [PIN_W-1:0]  pad_oe,
  input logic [PIN_W-1:0]  pad_out
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == REG_DIR |=> pad_oe == ~$past(bus_wdata)); // R2

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == REG_SET |=> pad_out == ($past(pad_out) | $past(bus_wdata))); // R3

  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == REG_CLR |=> pad_out == ($past(pad_out) & ~$past(bus_wdata))); // R4

  AST_OUT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == REG_OUT |=> pad_out == $past(bus_wdata)); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pad_out) && $stable(pad_oe)); // R9

  AST_IN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr >= REG_IN |=> $stable(pad_out) && $stable(pad_oe)); // R7

  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid); // R8

  AST_RVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid); // R8

  AST_LATCH_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_wr && (bus_addr == REG_OUT || bus_addr == REG_SET || bus_addr == REG_CLR)
    |=> bus_rdata == $past(pad_out)); // R6

  AST_IN_SYNC_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    since_rst == 2'd3 && bus_rd && bus_addr == REG_IN |=> bus_rdata == $past(pad_in, 3)); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr > REG_IN |=> bus_rdata == '0); // R8
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.PIN_W(PIN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .pad_in     (pad_in),
  .pad_oe     (pad_oe),
  .pad_out    (pad_out)
);

// File: tb/gpio_bank_ctrl_test.sv
module gpio_bank_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_oe;
  logic [31:0] pad_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_dir;
  logic [31:0] m_lat;

  always #2 clk = ~clk;

  gpio_bank_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R8 rvalid", {31'd0, bus_rvalid}, 32'd1);
    d = bus_rdata;
    @(negedge clk);
    chk("R8 rvalid drop", {31'd0, bus_rvalid}, 32'd0);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 oe", pad_oe, 32'h0);
    chk("R1 out", pad_out, 32'h0);
    rst_n = 1'b1;
    rd(3'd0, r); chk("R1 dir", r, 32'hFFFF_FFFF);
    rd(3'd1, r); chk("R1 latch", r, 32'h0);
    m_dir = '1; m_lat = '0;

    // R3 walking set across both banks, readback rotating OUT/SET/CLR (R6)
    for (int i = 0; i < 32; i++) begin
      m_lat = m_lat | (32'd1 << i);
      wr(3'd2, 32'd1 << i);
      chk("R3 set", pad_out, m_lat);
      rd(3'(1 + (i % 3)), r); chk("R6 readback", r, m_lat);
    end
    // R4 walking clear
    for (int i = 0; i < 32; i++) begin
      m_lat = m_lat & ~(32'd1 << i);
      wr(3'd3, 32'd1 << i);
      chk("R4 clear", pad_out, m_lat);
      rd(3'(1 + ((i + 1) % 3)), r); chk("R6 readback", r, m_lat);
    end
    // R3/R4 zero bits leave latches alone
    wr(3'd1, 32'hA5A5_0F0F); m_lat = 32'hA5A5_0F0F;
    chk("R5 load", pad_out, m_lat);
    wr(3'd2, 32'h0); chk("R3 zero no effect", pad_out, m_lat);
    wr(3'd3, 32'h0); chk("R4 zero no effect", pad_out, m_lat);
    wr(3'd2, 32'h0000_FFFF); m_lat = m_lat | 32'h0000_FFFF;
    chk("R3 lower bank", pad_out, m_lat);
    wr(3'd3, 32'hFFFF_0000); m_lat = m_lat & 32'h0000_FFFF;
    chk("R4 upper bank", pad_out, m_lat);

    // R2 direction patterns, R9 latch visible for inputs
    foreach (r[k]) begin end
    begin
      logic [31:0] pats [4] = '{32'h0000_0000, 32'hFFFF_0000, 32'h5555_AAAA, 32'h1234_8001};
      foreach (pats[j]) begin
        wr(3'd0, pats[j]); m_dir = pats[j];
        chk("R2 oe", pad_oe, ~m_dir);
        rd(3'd0, r); chk("R6 dir read", r, m_dir);
        chk("R9 out with inputs", pad_out, m_lat);
        rd(3'd1, r); chk("R6 latch indep of dir", r, m_lat);
      end
    end

    // R5 direct loads
    wr(3'd1, 32'hFFFF_FFFF); chk("R5 all ones", pad_out, 32'hFFFF_FFFF);
    wr(3'd1, 32'h0001_8000); m_lat = 32'h0001_8000;
    chk("R5 edge bits", pad_out, m_lat);

    // R7 input sync depth
    @(negedge clk); pad_in = 32'hDEAD_BEEF;
    repeat (4) @(negedge clk);
    rd(3'd4, r); chk("R7 in level", r, 32'hDEAD_BEEF);
    pad_in = 32'h1357_9BDF;         // change at a falling edge
    @(negedge clk);                 // one rising edge has passed
    bus_rd = 1'b1; bus_addr = 3'd4; // sampled at second edge after change
    @(negedge clk); bus_rd = 1'b0;
    chk("R7 one-stage old", bus_rdata, 32'hDEAD_BEEF);
    pad_in = 32'h2468_ACE0;
    @(negedge clk); @(negedge clk); // two rising edges passed
    bus_rd = 1'b1; bus_addr = 3'd4;
    @(negedge clk); bus_rd = 1'b0;
    chk("R7 two-stage new", bus_rdata, 32'h2468_ACE0);

    // R7 writes to input word ignored; R8 unmapped
    wr(3'd4, 32'h0F0F_F0F0);
    chk("R7 in write out", pad_out, m_lat);
    chk("R7 in write oe", pad_oe, ~m_dir);
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 32'hFFFF_FFFF);
      chk("R8 unmapped write", pad_out, m_lat);
      chk("R8 unmapped write dir", pad_oe, ~m_dir);
      rd(3'(a), r); chk("R8 unmapped read", r, 32'h0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule